// File: doc/BRIEF.md
# Two-Wire Debug Port Target

This block is the target end of a shared-pin programming port built from one clock line and one bidirectional data line. A host frames every transaction between a START strobe and a STOP strobe. In between, a two-bit instruction chooses one of four transfers: load the address register, read back a status byte, write a data register, or read a data register. Data transfers carry a two-bit byte count. They also carry a WAIT field that the target inserts itself, and that field paces the host until the selected register is ready.

The clock pin also acts as a reset pin. A free-running system clock measures each low period of the pin. A short low is a bit strobe. A very long low resets the target at once. A low of intermediate length is discarded. The pins reach the block already synchronous to the system clock, and the pad that merges the output and enable into one wire lies outside it. Behind the address register are two read-only identity registers, a mailbox that mimics a slow consumer, and a few scratch registers. The mailbox drives the status byte.

Top module: `twd_target`

## Requirements
- R1: The instruction's first bit goes to code bit 0 and its second bit to code bit 1. Code 00 is a data read, 01 a data write, 10 an address read and 11 an address write. Every field is sent LSB first and is sampled on the strobe's rising edge.
- R2: After reset the address register holds 0x00. A data read at 0x00 returns the DEV_ID parameter and a data read at 0x01 returns REV_ID.
- R3: A data write to 0x00 or 0x01 leaves both identity values unchanged. It sets the error flag, which stays set until the next reset.
- R4: A length field of value L moves L+1 bytes. On a write, the last byte received is stored. On a read, the first byte carries the register and every later byte is zero.
- R5: The WAIT field is some number of 0 bits followed by a single 1. At addresses 0x00 and 0x01 there are no 0 bits. At every other address there are WAIT_ZEROS of them. The field comes before the data on a read and after the data on a write.
- R6: An address read returns a status byte with these bits: busy in bit 7, error in bit 6, input-busy in bit 1 and output-ready in bit 0. Bits 5 to 2 are zero.
- R7: Writing the mailbox at 0x02 sets input-busy. ACCEPT_LAT system cycles later, input-busy clears and busy sets. PROC_LAT cycles after that, busy clears and output-ready sets. A data read of 0x02 then returns the bitwise inverse of the written byte and clears output-ready.
- R8: Addresses 0x03 to 0x03+N_SCR-1 are scratch registers that can be read and written. Every other address reads as zero, and writes to it change nothing.
- R9: The target enables its data driver only while it sends address-read bits, WAIT bits or read-data bits. It turns the driver on at the rising edge of the first strobe after the host releases the line, and turns it off at the rising edge of STOP.
- R10: When the clock pin stays low for RESET_LOW_CYC system cycles, the target resets at once, without waiting for the pin to rise. The frame state, address, status, scratch registers and driver all return to their reset values, and tgt_rst_pulse pulses once. The rising edge that ends this reset does not count as a START.
- R11: A low that lasts more than STROBE_MAX_CYC cycles but ends before the reset threshold is not taken as a strobe. The frame continues as if that strobe had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that measures low widths |
| rst | input | 1 | Synchronous active-high reset |
| pin_ck | input | 1 | Shared clock/reset pin, already synchronous to clk |
| pin_dat_i | input | 1 | Value the host places on the data line |
| pin_dat_o | output | 1 | Value the target drives on the data line |
| pin_dat_oe | output | 1 | Target data-driver enable |
| tgt_rst_pulse | output | 1 | One-cycle pulse when a long-low reset is detected |

## Verification
The assertions assume that pin_ck and pin_dat_i change only between system-clock edges. They also assume the host holds the data line steady from before a strobe's rising edge until after it, and that the host never drives in a field the target owns. The stimulus meets all three conditions: it changes pins only on falling clock edges, keeps ordinary strobes at four cycles low and four cycles high, and stays off the line during target fields. The undefined and reset low widths appear only in the directed cases that exercise them.

// File: rtl/twd_pkg.sv
package twd_pkg;

    // instruction code: bit 0 is the first bit received
    typedef enum logic [1:0] {
        INS_DRD = 2'b00,
        INS_DWR = 2'b01,
        INS_ARD = 2'b10,
        INS_AWR = 2'b11
    } ins_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INS0,
        ST_INS1,
        ST_LEN0,
        ST_LEN1,
        ST_AIN,
        ST_AOUT,
        ST_DIN,
        ST_WAIT,
        ST_DOUT,
        ST_STOP
    } fsm_e;

    typedef struct packed {
        logic busy;
        logic err;
        logic in_busy;
        logic out_rdy;
    } stat_t;

    typedef struct packed {
        logic       we;
        logic [7:0] data;
    } wr_req_t;

    localparam logic [7:0] ADDR_DEVID = 8'h00;
    localparam logic [7:0] ADDR_REVID = 8'h01;
    localparam logic [7:0] ADDR_MBOX  = 8'h02;
    localparam logic [7:0] ADDR_SCR0  = 8'h03;

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s.busy, s.err, 4'b0000, s.in_busy, s.out_rdy};
    endfunction

    function automatic logic is_id_addr(input logic [7:0] a);
        return (a == ADDR_DEVID) || (a == ADDR_REVID);
    endfunction

endpackage

// File: rtl/twd_pulse_meas.sv
module twd_pulse_meas #(
    parameter int STROBE_MAX_CYC = 250,
    parameter int RESET_LOW_CYC  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_ck,
    output logic strobe_o,
    output logic rst_evt_o,
    output logic rst_pulse_o
);
    localparam int CW = $clog2(RESET_LOW_CYC + 1);

    logic          ck_q;
    logic [CW-1:0] low_cnt;

    // a rise ends a valid strobe only if the low period was short enough
    assign strobe_o  = pin_ck && !ck_q && (low_cnt <= CW'(STROBE_MAX_CYC));
    // this cycle is the RESET_LOW_CYC-th consecutive low sample
    assign rst_evt_o = !pin_ck && (low_cnt == CW'(RESET_LOW_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q        <= 1'b1;
            low_cnt     <= '0;
            rst_pulse_o <= 1'b0;
        end else begin
            ck_q        <= pin_ck;
            rst_pulse_o <= rst_evt_o;
            if (pin_ck) begin
                low_cnt <= '0;
            end else if (low_cnt != CW'(RESET_LOW_CYC)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/twd_frame.sv
module twd_frame
    import twd_pkg::*;
#(
    parameter int WW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_evt_i,
    input  logic          strobe_i,
    input  logic          din_i,
    input  logic [7:0]    stat_byte_i,
    input  logic [7:0]    rd_data_i,
    input  logic [WW-1:0] wait_need_i,
    output logic [7:0]    addr_o,
    output wr_req_t       wr_o,
    output logic          rd_take_o,
    output logic          dout_o,
    output logic          doe_o
);
    fsm_e          state_q;
    logic          ins0_q;
    ins_e          ins_q;
    ins_e          ins_now;
    logic [1:0]    len_q;
    logic [7:0]    sh_q;
    logic [2:0]    bitc_q;
    logic [1:0]    bytec_q;
    logic [WW-1:0] waitc_q;
    logic [7:0]    sh_in;

    assign ins_now = ins_e'({din_i, ins0_q});
    assign sh_in   = {din_i, sh_q[7:1]};

    always_ff @(posedge clk) begin
        wr_o.we   <= 1'b0;
        rd_take_o <= 1'b0;
        if (rst || rst_evt_i) begin
            state_q   <= ST_IDLE;
            ins0_q    <= 1'b0;
            ins_q     <= INS_DRD;
            len_q     <= '0;
            sh_q      <= '0;
            bitc_q    <= '0;
            bytec_q   <= '0;
            waitc_q   <= '0;
            addr_o    <= ADDR_DEVID;
            wr_o.data <= '0;
            dout_o    <= 1'b0;
            doe_o     <= 1'b0;
        end else if (strobe_i) begin
            unique case (state_q)
                ST_IDLE: state_q <= ST_INS0;
                ST_INS0: begin
                    ins0_q  <= din_i;
                    state_q <= ST_INS1;
                end
                ST_INS1: begin
                    ins_q   <= ins_now;
                    bitc_q  <= '0;
                    bytec_q <= '0;
                    waitc_q <= '0;
                    unique case (ins_now)
                        INS_AWR: state_q <= ST_AIN;
                        INS_ARD: begin
                            sh_q    <= stat_byte_i;
                            state_q <= ST_AOUT;
                        end
                        default: state_q <= ST_LEN0;
                    endcase
                end
                ST_LEN0: begin
                    len_q[0] <= din_i;
                    state_q  <= ST_LEN1;
                end
                ST_LEN1: begin
                    len_q[1] <= din_i;
                    state_q  <= (ins_q == INS_DRD) ? ST_WAIT : ST_DIN;
                end
                ST_AIN: begin
                    sh_q   <= sh_in;
                    bitc_q <= bitc_q + 1'b1;
                    if (bitc_q == 3'd7) begin
                        addr_o  <= sh_in;
                        state_q <= ST_STOP;
                    end
                end
                ST_AOUT: begin
                    doe_o  <= 1'b1;
                    dout_o <= sh_q[0];
                    sh_q   <= {1'b0, sh_q[7:1]};
                    bitc_q <= bitc_q + 1'b1;
                    if (bitc_q == 3'd7) state_q <= ST_STOP;
                end
                ST_DIN: begin
                    sh_q   <= sh_in;
                    bitc_q <= bitc_q + 1'b1;
                    if (bitc_q == 3'd7) begin
                        if (bytec_q == len_q) begin
                            wr_o.we   <= 1'b1;
                            wr_o.data <= sh_in;
                            state_q   <= ST_WAIT;
                        end else begin
                            bytec_q <= bytec_q + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    doe_o <= 1'b1;
                    if (waitc_q == wait_need_i) begin
                        dout_o <= 1'b1;
                        if (ins_q == INS_DWR) begin
                            state_q <= ST_STOP;
                        end else begin
                            sh_q      <= rd_data_i;
                            rd_take_o <= 1'b1;
                            bitc_q    <= '0;
                            bytec_q   <= '0;
                            state_q   <= ST_DOUT;
                        end
                    end else begin
                        dout_o  <= 1'b0;
                        waitc_q <= waitc_q + 1'b1;
                    end
                end
                ST_DOUT: begin
                    dout_o <= sh_q[0];
                    sh_q   <= {1'b0, sh_q[7:1]};
                    bitc_q <= bitc_q + 1'b1;
                    if (bitc_q == 3'd7) begin
                        if (bytec_q == len_q) state_q <= ST_STOP;
                        else bytec_q <= bytec_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    doe_o   <= 1'b0;
                    dout_o  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twd_regs.sv
module twd_regs
    import twd_pkg::*;
#(
    parameter logic [7:0] DEV_ID     = 8'h3C,
    parameter logic [7:0] REV_ID     = 8'h07,
    parameter int         N_SCR      = 4,
    parameter int         WAIT_ZEROS = 3,
    parameter int         ACCEPT_LAT = 200,
    parameter int         PROC_LAT   = 400,
    parameter int         WW         = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_evt_i,
    input  logic [7:0]    addr_i,
    input  wr_req_t       wr_i,
    input  logic          rd_take_i,
    output logic [7:0]    rd_data_o,
    output logic [WW-1:0] wait_need_o,
    output stat_t         stat_o
);
    localparam int MAXLAT = (ACCEPT_LAT > PROC_LAT) ? ACCEPT_LAT : PROC_LAT;
    localparam int LW     = $clog2(MAXLAT + 1);

    logic              clr;
    logic [N_SCR-1:0]  scr_hit;
    logic [7:0]        scr_q [N_SCR];
    logic [7:0]        mb_val_q;
    logic [7:0]        reply_q;
    logic [LW-1:0]     lat_q;
    logic              mb_wr;

    assign clr   = rst || rst_evt_i;
    assign mb_wr = wr_i.we && (addr_i == ADDR_MBOX);

    for (genvar g = 0; g < N_SCR; g++) begin : g_scr
        logic [7:0] q;
        assign scr_hit[g] = (addr_i == 8'(ADDR_SCR0 + g));
        always_ff @(posedge clk) begin
            if (clr) q <= '0;
            else if (wr_i.we && scr_hit[g]) q <= wr_i.data;
        end
        assign scr_q[g] = q;
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (addr_i == ADDR_DEVID) rd_data_o = DEV_ID;
        else if (addr_i == ADDR_REVID) rd_data_o = REV_ID;
        else if (addr_i == ADDR_MBOX) rd_data_o = reply_q;
        else begin
            for (int i = 0; i < N_SCR; i++) begin
                if (scr_hit[i]) rd_data_o = scr_q[i];
            end
        end
    end

    assign wait_need_o = is_id_addr(addr_i) ? '0 : WW'(WAIT_ZEROS);

    // error flag: sticky until reset
    always_ff @(posedge clk) begin
        if (clr) stat_o.err <= 1'b0;
        else if (wr_i.we && is_id_addr(addr_i)) stat_o.err <= 1'b1;
    end

    // mailbox: accept, process, present reply
    always_ff @(posedge clk) begin
        if (clr) begin
            stat_o.in_busy <= 1'b0;
            stat_o.busy    <= 1'b0;
            stat_o.out_rdy <= 1'b0;
            mb_val_q       <= '0;
            reply_q        <= '0;
            lat_q          <= '0;
        end else begin
            if (stat_o.in_busy) begin
                if (lat_q == LW'(ACCEPT_LAT - 1)) begin
                    stat_o.in_busy <= 1'b0;
                    stat_o.busy    <= 1'b1;
                    lat_q          <= '0;
                end else begin
                    lat_q <= lat_q + 1'b1;
                end
            end else if (stat_o.busy) begin
                if (lat_q == LW'(PROC_LAT - 1)) begin
                    stat_o.busy    <= 1'b0;
                    stat_o.out_rdy <= 1'b1;
                    reply_q        <= ~mb_val_q;
                    lat_q          <= '0;
                end else begin
                    lat_q <= lat_q + 1'b1;
                end
            end else if (mb_wr) begin
                stat_o.in_busy <= 1'b1;
                mb_val_q       <= wr_i.data;
                lat_q          <= '0;
            end
            if (rd_take_i && (addr_i == ADDR_MBOX)) stat_o.out_rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/twd_target.sv
module twd_target
    import twd_pkg::*;
#(
    parameter logic [7:0] DEV_ID         = 8'h3C,
    parameter logic [7:0] REV_ID         = 8'h07,
    parameter int         N_SCR          = 4,
    parameter int         WAIT_ZEROS     = 3,
    parameter int         ACCEPT_LAT     = 200,
    parameter int         PROC_LAT       = 400,
    parameter int         STROBE_MAX_CYC = 250,
    parameter int         RESET_LOW_CYC  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_ck,
    input  logic pin_dat_i,
    output logic pin_dat_o,
    output logic pin_dat_oe,
    output logic tgt_rst_pulse
);
    localparam int WW = (WAIT_ZEROS < 1) ? 1 : $clog2(WAIT_ZEROS + 1);

    logic          strobe;
    logic          rst_evt;
    logic [7:0]    addr_q;
    wr_req_t       wr_req;
    logic          rd_take;
    logic [7:0]    rd_data;
    logic [WW-1:0] wait_need;
    stat_t         stat;

    twd_pulse_meas #(
        .STROBE_MAX_CYC(STROBE_MAX_CYC),
        .RESET_LOW_CYC (RESET_LOW_CYC)
    ) u_meas (
        .clk        (clk),
        .rst        (rst),
        .pin_ck     (pin_ck),
        .strobe_o   (strobe),
        .rst_evt_o  (rst_evt),
        .rst_pulse_o(tgt_rst_pulse)
    );

    twd_frame #(.WW(WW)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .rst_evt_i  (rst_evt),
        .strobe_i   (strobe),
        .din_i      (pin_dat_i),
        .stat_byte_i(stat_byte(stat)),
        .rd_data_i  (rd_data),
        .wait_need_i(wait_need),
        .addr_o     (addr_q),
        .wr_o       (wr_req),
        .rd_take_o  (rd_take),
        .dout_o     (pin_dat_o),
        .doe_o      (pin_dat_oe)
    );

    twd_regs #(
        .DEV_ID    (DEV_ID),
        .REV_ID    (REV_ID),
        .N_SCR     (N_SCR),
        .WAIT_ZEROS(WAIT_ZEROS),
        .ACCEPT_LAT(ACCEPT_LAT),
        .PROC_LAT  (PROC_LAT),
        .WW        (WW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rst_evt_i  (rst_evt),
        .addr_i     (addr_q),
        .wr_i       (wr_req),
        .rd_take_i  (rd_take),
        .rd_data_o  (rd_data),
        .wait_need_o(wait_need),
        .stat_o     (stat)
    );
endmodule

// File: rtl/twd_target_chk.sv
module twd_target_chk
    import twd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       strobe,
    input logic       rst_evt,
    input logic       doe,
    input logic       dout,
    input logic [7:0] addr,
    input stat_t      stat
);
    AST_RESET_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
        rst_evt |=> !doe);                                   // R10
    AST_RESET_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        rst_evt |=> (addr == 8'h00));                        // R10
    AST_OE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !rst_evt) |=> $stable(doe));             // R9
    AST_DOUT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !rst_evt) |=> $stable(dout));            // R9
    AST_ADDR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !rst_evt) |=> $stable(addr));            // R11
    AST_MBOX_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stat.in_busy && stat.busy));                       // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat.err && !rst_evt) |=> stat.err);                // R3
endmodule

bind twd_target twd_target_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rst_evt(rst_evt),
    .doe    (pin_dat_oe),
    .dout   (pin_dat_o),
    .addr   (addr_q),
    .stat   (stat)
);

// File: tb/twd_target_bench.sv
`timescale 1ns/1ps
module twd_target_bench;
    localparam int         LO = 4;
    localparam int         HI = 4;
    localparam int         N_SCR = 4;
    localparam int         WAIT_ZEROS = 3;
    localparam int         RESET_LOW_CYC = 1000;
    localparam logic [7:0] DEV_ID = 8'h3C;
    localparam logic [7:0] REV_ID = 8'h07;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ck  = 1'b1;
    logic di  = 1'b0;
    logic dout, doe, trst;

    int   checks = 0;
    int   errors = 0;
    int   rst_pulses = 0;
    bit   finished = 0;
    logic exp_err = 1'b0;
    logic [7:0] scr_m [N_SCR];

    always #10 clk = ~clk;
    always @(posedge clk) if (!rst && trst) rst_pulses++;

    twd_target #(
        .DEV_ID(DEV_ID), .REV_ID(REV_ID), .N_SCR(N_SCR), .WAIT_ZEROS(WAIT_ZEROS),
        .ACCEPT_LAT(200), .PROC_LAT(400), .STROBE_MAX_CYC(250), .RESET_LOW_CYC(RESET_LOW_CYC)
    ) u_twd_target (
        .clk(clk), .rst(rst), .pin_ck(ck), .pin_dat_i(di),
        .pin_dat_o(dout), .pin_dat_oe(doe), .tgt_rst_pulse(trst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h00) return DEV_ID;
        if (a == 8'h01) return REV_ID;
        if (a >= 8'h03 && a < 8'(3 + N_SCR)) return scr_m[a - 8'h03];
        return 8'h00;
    endfunction

    function automatic int exp_wait(input logic [7:0] a);
        return (a <= 8'h01) ? 0 : WAIT_ZEROS;
    endfunction

    function automatic logic [7:0] exp_stat();
        return {1'b0, exp_err, 6'b000000};
    endfunction

    task automatic strobe(input logic drv, input logic b, input logic exp_oe, output logic got);
        @(negedge clk);
        di = drv ? b : 1'b0;
        ck = 1'b0;
        repeat (LO) @(negedge clk);
        ck = 1'b1;
        repeat (HI) @(negedge clk);
        got = dout;
        check("R9 driver enable", 32'(doe), 32'(exp_oe));
    endtask

    task automatic aw(input logic [7:0] a);
        logic g;
        strobe(0, 0, 0, g);
        strobe(1, 1, 0, g);
        strobe(1, 1, 0, g);
        for (int i = 0; i < 8; i++) strobe(1, a[i], 0, g);
        strobe(0, 0, 0, g);
    endtask

    task automatic ar(output logic [7:0] s);
        logic g;
        strobe(0, 0, 0, g);
        strobe(1, 0, 0, g);
        strobe(1, 1, 0, g);
        for (int i = 0; i < 8; i++) begin
            strobe(0, 0, 1, g);
            s[i] = g;
        end
        strobe(0, 0, 0, g);
    endtask

    task automatic dw(input logic [1:0] len, input logic [31:0] d, output int nz);
        logic g;
        nz = 0;
        strobe(0, 0, 0, g);
        strobe(1, 1, 0, g);
        strobe(1, 0, 0, g);
        strobe(1, len[0], 0, g);
        strobe(1, len[1], 0, g);
        for (int i = 0; i < (int'(len) + 1) * 8; i++) strobe(1, d[i], 0, g);
        g = 1'b0;
        while (!g && nz <= 16) begin
            strobe(0, 0, 1, g);
            if (!g) nz++;
        end
        strobe(0, 0, 0, g);
    endtask

    task automatic dr(input logic [1:0] len, output logic [31:0] d, output int nz);
        logic g;
        nz = 0;
        d  = '0;
        strobe(0, 0, 0, g);
        strobe(1, 0, 0, g);
        strobe(1, 0, 0, g);
        strobe(1, len[0], 0, g);
        strobe(1, len[1], 0, g);
        g = 1'b0;
        while (!g && nz <= 16) begin
            strobe(0, 0, 1, g);
            if (!g) nz++;
        end
        for (int i = 0; i < (int'(len) + 1) * 8; i++) begin
            strobe(0, 0, 1, g);
            d[i] = g;
        end
        strobe(0, 0, 0, g);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [1:0] len, input logic [31:0] d);
        int nz;
        aw(a);
        dw(len, d, nz);
        check("R5 write WAIT zeros", 32'(nz), 32'(exp_wait(a)));
        if (a <= 8'h01) exp_err = 1'b1;
        else if (a >= 8'h03 && a < 8'(3 + N_SCR)) scr_m[a - 8'h03] = d[8*len +: 8];
    endtask

    task automatic do_read(input logic [7:0] a, input logic [1:0] len, input string req);
        int nz;
        logic [31:0] d;
        aw(a);
        dr(len, d, nz);
        check("R5 read WAIT zeros", 32'(nz), 32'(exp_wait(a)));
        check(req, d, {24'h0, exp_rd(a)});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  s;
        logic [31:0] d;
        int          nz;
        int          p0;
        logic        g;
        bit          seen_busy;
        bit          done;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N_SCR; i++) scr_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset: driver off", 32'(doe), 32'd0);
        check("R9 reset: data low", 32'(dout), 32'd0);
        check("R10 reset: no pulse", 32'(trst), 32'd0);

        // R2: address defaults to device ID; R1 decode of data read
        dr(2'd0, d, nz);
        check("R2 default address reads DEV_ID", d, {24'h0, DEV_ID});
        check("R5 ID read has no WAIT zeros", 32'(nz), 32'd0);
        ar(s);
        check("R6 idle status byte", 32'(s), 32'(exp_stat()));
        do_read(8'h01, 2'd0, "R1 R2 address write then REV_ID read");

        // R3: writes to ID registers
        do_write(8'h00, 2'd0, 32'h0000_00FF);
        ar(s);
        check("R3 R6 error flag in bit 6", 32'(s), 32'h40);
        do_read(8'h00, 2'd0, "R3 DEV_ID unchanged");
        do_write(8'h01, 2'd1, 32'h0000_1234);
        do_read(8'h01, 2'd1, "R3 REV_ID unchanged, R4 upper byte zero");

        // R4: multi-byte write keeps last byte, read right-justified
        do_write(8'h03, 2'd3, 32'h4433_2211);
        check("R4 model last byte", 32'(scr_m[0]), 32'h44);
        do_read(8'h03, 2'd3, "R4 four-byte read");
        do_read(8'h03, 2'd2, "R4 three-byte read");

        // R8: unmapped address
        do_write(8'h90, 2'd0, 32'h0000_00AB);
        do_read(8'h90, 2'd0, "R8 unmapped reads zero");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int r;
            logic [7:0] a;
            logic [1:0] len;
            logic [31:0] wd;
            r   = int'($urandom % 10);
            len = 2'($urandom % 4);
            wd  = $urandom;
            if (r < 2) a = 8'(r);
            else if (r < 6) a = 8'(3 + r - 2);
            else a = 8'($urandom_range(7, 255));
            if ($urandom % 2 == 0) do_write(a, len, wd);
            else do_read(a, len, "R8 R4 random read");
        end
        ar(s);
        check("R6 status after random mix", 32'(s), 32'(exp_stat()));

        // R7: mailbox handshake
        aw(8'h02);
        dw(2'd0, 32'h0000_00C3, nz);
        check("R5 mailbox WAIT zeros", 32'(nz), 32'(WAIT_ZEROS));
        ar(s);
        check("R7 input-busy after write", 32'(s), 32'({1'b0, exp_err, 4'b0, 2'b10}));
        seen_busy = 0;
        done = 0;
        for (int k = 0; k < 40 && !done; k++) begin
            ar(s);
            if (s[7] && !s[1]) seen_busy = 1;
            if (s[0]) done = 1;
        end
        check("R7 busy phase observed", 32'(seen_busy), 32'd1);
        check("R7 output-ready status", 32'(s), 32'({1'b0, exp_err, 4'b0, 2'b01}));
        dr(2'd0, d, nz);
        check("R7 reply is inverse", d, 32'h0000_003C);
        ar(s);
        check("R7 output-ready cleared by read", 32'(s), 32'(exp_stat()));

        // R11: an over-long low inside an address write is ignored
        do_write(8'h04, 2'd0, 32'h0000_006E);
        aw(8'h00);
        p0 = rst_pulses;
        strobe(0, 0, 0, g);
        strobe(1, 1, 0, g);
        strobe(1, 1, 0, g);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                @(negedge clk);
                di = 1'b1;
                ck = 1'b0;
                repeat (500) @(negedge clk);
                ck = 1'b1;
                repeat (HI) @(negedge clk);
                check("R11 driver stays off", 32'(doe), 32'd0);
            end
            strobe(1, i == 2, 0, g);
        end
        strobe(0, 0, 0, g);
        dr(2'd0, d, nz);
        check("R11 address intact after ignored low", d, 32'h0000_006E);
        check("R11 no reset pulse", 32'(rst_pulses - p0), 32'd0);

        // R10: long-low reset in the middle of an address read
        aw(8'h05);
        p0 = rst_pulses;
        strobe(0, 0, 0, g);
        strobe(1, 0, 0, g);
        strobe(1, 1, 0, g);
        strobe(0, 0, 1, g);
        @(negedge clk);
        ck = 1'b0;
        repeat (RESET_LOW_CYC + 5) @(negedge clk);
        check("R10 driver off while pin still low", 32'(doe), 32'd0);
        check("R10 one reset pulse", 32'(rst_pulses - p0), 32'd1);
        ck = 1'b1;
        repeat (20) @(negedge clk);
        exp_err = 1'b0;
        for (int i = 0; i < N_SCR; i++) scr_m[i] = 8'h00;
        ar(s);
        check("R10 status cleared", 32'(s), 32'h00);
        dr(2'd0, d, nz);
        check("R10 address back to DEV_ID", d, {24'h0, DEV_ID});
        do_read(8'h03, 2'd0, "R10 scratch cleared");
        do_read(8'h04, 2'd0, "R10 scratch cleared");

        finish_run();
    end
endmodule